// File: doc/BRIEF.md
# Floating-Point NaN Classifier

This block looks at one floating-point operand per cycle and reports whether it is a quiet NaN, a signaling NaN, or a NaN of either kind. The operand arrives right-aligned on a 128-bit bus. A 3-bit select names its format: half, bfloat16, single, double, 80-bit extended or quad. The flags come out of registers one clock after the input strobe, together with a matching valid bit.

Two mode inputs set how quiet and signaling NaNs are told apart. The polarity input chooses which value of the most significant fraction bit marks a signaling NaN. The no-signaling input declares that the target has no signaling NaNs at all, so every NaN is reported as quiet. A decoder, a NaN-propagation stage or an exception unit would place this block in front of its datapath to steer special-value handling.

Top module: `fp_nan_sort`

## Requirements
- R1: A synchronous active-high reset clears `out_vld`, `is_qnan`, `is_snan` and `is_nan`.
- R2: `out_vld` equals `in_vld` from one clock earlier. While `out_vld` is low, all three flags are zero.
- R3: Format codes are 0 half, 1 bfloat16, 2 single, 3 double, 4 80-bit extended and 5 quad. Codes 6 and 7 give all flags zero. Operand bits above the selected format's width are ignored.
- R4: Field positions, given as exponent / top fraction bit / remaining fraction. Half: [14:10] / 9 / [8:0]. bfloat16: [14:7] / 6 / [5:0]. Single: [30:23] / 22 / [21:0]. Double: [62:52] / 51 / [50:0]. Quad: [126:112] / 111 / [110:0].
- R5: With `snan_pol`=0, an operand is a quiet NaN when its exponent is all ones and its top fraction bit is 1. It is a signaling NaN when its exponent is all ones, its top fraction bit is 0 and its remaining fraction is nonzero.
- R6: With `snan_pol`=1, the two tests swap. An all-ones exponent with the top fraction bit 1 is signaling. An all-ones exponent with the top bit 0 and a nonzero remaining fraction is quiet.
- R7: For the 80-bit extended format, the exponent is [78:64] and must be 0x7FFF. Bit 63 is the explicit integer bit and has no effect. Bit 62 is the top fraction bit and [61:0] is the remaining fraction. The rules of R5 and R6 then apply.
- R8: With `no_snan`=1, `is_snan` is always zero and `is_qnan` is high for every NaN, whatever the value of `snan_pol`.
- R9: Infinities, zeros, normal and subnormal numbers of either sign give all flags zero.
- R10: `is_nan` equals `is_qnan` OR `is_snan`, and `is_qnan` and `is_snan` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe |
| fmt | input | 3 | Format select (see R3) |
| opnd | input | 128 | Operand, right-aligned |
| snan_pol | input | 1 | 1: top fraction bit set marks signaling |
| no_snan | input | 1 | 1: every NaN is treated as quiet |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| is_qnan | output | 1 | Quiet NaN flag |
| is_snan | output | 1 | Signaling NaN flag |
| is_nan | output | 1 | Any-NaN flag |

## Verification
The only state is one register stage, so any fault in the field mux or the classification shows up on the flags in the cycle right after the strobe. A wrong field position shows as a missed NaN, or as an infinity flagged as a NaN, for exactly one format. A reversed polarity swaps the quiet and signaling flags. For the 80-bit format, a test that wrongly reads the integer bit shows up on operands whose bit 63 is clear. A stale or misaligned valid bit shows up as a flag on an idle cycle, or as `out_vld` one cycle off from the strobe.

// File: rtl/fp_nan_sort.sv
module fp_nan_sort (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [2:0]   fmt,
  input  logic [127:0] opnd,
  input  logic         snan_pol,
  input  logic         no_snan,
  output logic         out_vld,
  output logic         is_qnan,
  output logic         is_snan,
  output logic         is_nan
);

  localparam logic [2:0] F_HALF = 3'd0;
  localparam logic [2:0] F_BF16 = 3'd1;
  localparam logic [2:0] F_SGL  = 3'd2;
  localparam logic [2:0] F_DBL  = 3'd3;
  localparam logic [2:0] F_EXT  = 3'd4;
  localparam logic [2:0] F_QUAD = 3'd5;

  logic exp_ones, top_bit, rest_nz;
  logic nan_c, sig_c, qui_c;
  logic unused_bits;

  assign unused_bits = ^{opnd[127], opnd[79], opnd[63], opnd[31], opnd[15]};

  always_comb begin
    exp_ones = 1'b0;
    top_bit  = 1'b0;
    rest_nz  = 1'b0;
    case (fmt)
      F_HALF: begin
        exp_ones = &opnd[14:10];
        top_bit  = opnd[9];
        rest_nz  = |opnd[8:0];
      end
      F_BF16: begin
        exp_ones = &opnd[14:7];
        top_bit  = opnd[6];
        rest_nz  = |opnd[5:0];
      end
      F_SGL: begin
        exp_ones = &opnd[30:23];
        top_bit  = opnd[22];
        rest_nz  = |opnd[21:0];
      end
      F_DBL: begin
        exp_ones = &opnd[62:52];
        top_bit  = opnd[51];
        rest_nz  = |opnd[50:0];
      end
      F_EXT: begin
        exp_ones = &opnd[78:64];
        top_bit  = opnd[62];
        rest_nz  = |opnd[61:0];
      end
      F_QUAD: begin
        exp_ones = &opnd[126:112];
        top_bit  = opnd[111];
        rest_nz  = |opnd[110:0];
      end
      default: ;
    endcase
  end

  assign nan_c = exp_ones & (top_bit | rest_nz);
  assign sig_c = ~no_snan & nan_c & (top_bit == snan_pol);
  assign qui_c = nan_c & ~sig_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      is_qnan <= 1'b0;
      is_snan <= 1'b0;
      is_nan  <= 1'b0;
    end else begin
      out_vld <= in_vld;
      is_qnan <= in_vld & qui_c;
      is_snan <= in_vld & sig_c;
      is_nan  <= in_vld & nan_c;
    end
  end

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R2
  AST_VLD_FALL: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !out_vld |-> !(is_qnan | is_snan | is_nan)); // R2
  AST_KIND_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({is_qnan, is_snan})); // R10
  AST_ANY_OR: assert property (@(posedge clk) disable iff (rst) is_nan == (is_qnan | is_snan)); // R10
  AST_NO_SIG: assert property (@(posedge clk) disable iff (rst) (in_vld && no_snan) |=> !is_snan); // R8
  AST_RSVD_FMT: assert property (@(posedge clk) disable iff (rst) (in_vld && fmt > F_QUAD) |=> !is_nan); // R3
  AST_RST_CLR: assert property (@(posedge clk) $past(rst) |-> !(out_vld | is_nan)); // R1

endmodule

// File: tb/fp_nan_sort_tb.sv
module fp_nan_sort_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [2:0] fmt = 3'd0;
  logic [127:0] opnd = '0;
  logic snan_pol = 1'b0;
  logic no_snan = 1'b0;
  logic out_vld, is_qnan, is_snan, is_nan;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fp_nan_sort u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .fmt(fmt), .opnd(opnd),
    .snan_pol(snan_pol), .no_snan(no_snan),
    .out_vld(out_vld), .is_qnan(is_qnan), .is_snan(is_snan), .is_nan(is_nan)
  );

  task automatic chk(input string req, input logic [2:0] f, input logic [127:0] v,
                     input logic pol, input logic ns, input logic eq, input logic es);
    @(negedge clk);
    in_vld = 1'b1; fmt = f; opnd = v; snan_pol = pol; no_snan = ns;
    @(negedge clk);
    in_vld = 1'b0;
    checks++;
    if ({out_vld, is_qnan, is_snan, is_nan} !== {1'b1, eq, es, eq | es}) begin
      errors++;
      $display("FAIL %s fmt=%0d op=%h: vld/q/s/n actual %b%b%b%b expected 1%b%b%b",
               req, f, v, out_vld, is_qnan, is_snan, is_nan, eq, es, eq | es);
    end
  endtask

  task automatic chk_idle(input string req);
    @(negedge clk);
    checks++;
    if ({out_vld, is_qnan, is_snan, is_nan} !== 4'b0000) begin
      errors++;
      $display("FAIL %s idle: actual %b%b%b%b expected 0000", req, out_vld, is_qnan, is_snan, is_nan);
    end
  endtask

  task automatic t_reset;
    in_vld = 1'b1; fmt = 3'd0; opnd = 128'h7E00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({out_vld, is_qnan, is_snan, is_nan} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 reset: actual %b%b%b%b expected 0000", out_vld, is_qnan, is_snan, is_nan);
    end
    in_vld = 1'b0;
    rst = 1'b0;
    chk_idle("R2");
  endtask

  task automatic t_half_bf16;
    chk("R5", 3'd0, 128'h7E00, 0, 0, 1, 0);
    chk("R5", 3'd0, 128'h7C01, 0, 0, 0, 1);
    chk("R9", 3'd0, 128'h7C00, 0, 0, 0, 0);
    chk("R9", 3'd0, 128'h3C00, 0, 0, 0, 0);
    chk("R5", 3'd0, 128'hFE00, 0, 0, 1, 0);
    chk("R4", 3'd1, 128'h7FC0, 0, 0, 1, 0);
    chk("R4", 3'd1, 128'h7F81, 0, 0, 0, 1);
    chk("R9", 3'd1, 128'hFF80, 0, 0, 0, 0);
    chk_idle("R2");
  endtask

  task automatic t_sgl_dbl;
    chk("R4", 3'd2, 128'h7FC00000, 0, 0, 1, 0);
    chk("R4", 3'd2, 128'h7F800001, 0, 0, 0, 1);
    chk("R9", 3'd2, 128'h7F800000, 0, 0, 0, 0);
    chk("R3", 3'd2, {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'h3F800000}, 0, 0, 0, 0);
    chk("R4", 3'd3, 128'h7FF80000_00000000, 0, 0, 1, 0);
    chk("R4", 3'd3, 128'h7FF00000_00000001, 0, 0, 0, 1);
    chk("R9", 3'd3, 128'h7FF00000_00000000, 0, 0, 0, 0);
    chk("R9", 3'd3, 128'h00000000_00000001, 0, 0, 0, 0);
  endtask

  task automatic t_ext;
    chk("R7", 3'd4, {48'h0, 16'h7FFF, 64'hC000000000000000}, 0, 0, 1, 0);
    chk("R7", 3'd4, {48'h0, 16'h7FFF, 64'h8000000000000001}, 0, 0, 0, 1);
    chk("R7", 3'd4, {48'h0, 16'h7FFF, 64'h8000000000000000}, 0, 0, 0, 0);
    chk("R7", 3'd4, {48'h0, 16'h7FFF, 64'h4000000000000000}, 0, 0, 1, 0);
    chk("R7", 3'd4, {48'h0, 16'h7FFF, 64'h0000000000000001}, 0, 0, 0, 1);
    chk("R7", 3'd4, {48'h0, 16'hFFFF, 64'hC000000000000000}, 1, 0, 0, 1);
    chk("R7", 3'd4, {48'h0, 16'h7FFF, 64'h8000000000000001}, 1, 0, 1, 0);
    chk("R9", 3'd4, {48'h0, 16'h3FFF, 64'hC000000000000000}, 0, 0, 0, 0);
  endtask

  task automatic t_quad;
    chk("R4", 3'd5, 128'h7FFF8000_00000000_00000000_00000000, 0, 0, 1, 0);
    chk("R4", 3'd5, 128'h7FFF0000_00000000_00000000_00000001, 0, 0, 0, 1);
    chk("R4", 3'd5, 128'h7FFF4000_00000000_00000000_00000000, 0, 0, 0, 1);
    chk("R9", 3'd5, 128'hFFFF0000_00000000_00000000_00000000, 0, 0, 0, 0);
    chk("R6", 3'd5, 128'h7FFF8000_00000000_00000000_00000000, 1, 0, 0, 1);
  endtask

  task automatic t_modes;
    chk("R6", 3'd0, 128'h7E00, 1, 0, 0, 1);
    chk("R6", 3'd0, 128'h7C01, 1, 0, 1, 0);
    chk("R6", 3'd0, 128'h7C00, 1, 0, 0, 0);
    chk("R6", 3'd2, 128'h7F800001, 1, 0, 1, 0);
    chk("R8", 3'd0, 128'h7C01, 0, 1, 1, 0);
    chk("R8", 3'd0, 128'h7E00, 1, 1, 1, 0);
    chk("R8", 3'd3, 128'h7FF00000_00000001, 0, 1, 1, 0);
    chk("R8", 3'd4, {48'h0, 16'h7FFF, 64'h8000000000000000}, 0, 1, 0, 0);
    chk("R3", 3'd6, 128'h7E00, 0, 0, 0, 0);
    chk("R3", 3'd7, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 0, 0, 0, 0);
    chk_idle("R2");
  endtask

  initial begin
    t_reset();
    t_half_bf16();
    t_sgl_dbl();
    t_ext();
    t_quad();
    t_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule